// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Master

This block is a three-wire serial master with an eight-bit frame, driven through a small register port. Software writes a byte into a transmit holding register. The block moves that byte into a shift register and clocks it out most-significant bit first on `mosi`. At the same time it shifts `miso` into the shifter. When all eight bits are in, the received byte lands in a receive register. Chip select is not part of the block; software drives it from a general-purpose pin.

The holding register sits in front of the shifter, so software can load the next byte while the current one is still being sent. The transmit-ready flag rises at the start of each byte, when the holding register empties into the shifter. If the next byte is written before the current one ends, it follows with no idle bit period. A vector register reports the highest-priority pending interrupt source that is enabled, and receive takes priority over transmit. Reading the vector clears the flag it reported, so an interrupt handler can service both sources by reading the vector over and over.

Register map (3-bit word address): 0 control (bit 0 = soft reset, reads 1 after reset), 1 bit-clock divisor (16 bits, reset value 2), 2 transmit holding (write, bits 7:0), 3 receive buffer (read, bits 7:0), 4 interrupt enable (bit 0 receive, bit 1 transmit), 5 flags (read-only: bit 0 receive-complete, bit 1 transmit-ready, bit 2 overrun), 6 vector (read). A read is any cycle with `bus_sel` high and `bus_wr` low. Read data is combinational in that cycle, and any clear-on-read takes effect at the following clock edge.

Top module: `spim_top`

## Requirements
- R1: After reset the control register reads 1, the divisor reads 2, the flags and vector read 0, and `sclk` and `mosi` are low.
- R2: While soft reset (control bit 0) is 1, no transfer starts, `sclk` stays low, and a write to the transmit holding register is discarded, so it is never sent later.
- R3: The write that clears soft reset sets the transmit-ready flag (flags bit 1) at once.
- R4: A byte is sent most-significant bit first as 8 `sclk` rising edges spaced by the divisor in clock cycles. `sclk` is low for the first floor(div/2) cycles of each bit, and `mosi` is stable while `sclk` is high.
- R5: The transmit-ready flag sets on the cycle after the holding register is copied into the shifter, at the start of a byte. A write to the holding register clears it.
- R6: If the holding register is written before the current byte ends, the next byte starts with no gap: the spacing of the `sclk` rising edges stays at the divisor across the byte boundary. With no pending byte, `sclk` stays low.
- R7: When the eighth bit is sampled, the received byte (sampled from `miso` at the end of each bit's high phase) goes into the receive buffer and sets the receive-complete flag (flags bit 0). Reading the receive buffer clears that flag.
- R8: A byte that completes while receive-complete is still set sets overrun (flags bit 2) and overwrites the buffer. Reading the receive buffer clears overrun.
- R9: The vector reads 2 when receive-complete is set and enabled (enable bit 0). Otherwise it reads 4 when transmit-ready is set and enabled (enable bit 1). Otherwise it reads 0. A pending source whose enable bit is clear is not reported.
- R10: Reading the vector clears only the flag whose code it returned.
- R11: Divisor values 0 and 1 act as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial bit clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A shifter whose bit counter or reload logic is wrong shows up at `sclk` within one byte. The count of rising edges moves away from eight, or the edge spacing stretches at the boundary between two bytes. A flag register set or cleared on the wrong event shows up at the next read of the flags or the vector: the ready flag stays high after a holding write, overrun is missing after two unread bytes, or the vector order is reversed. The bench loops `mosi` back into `miso` and rebuilds each byte from `mosi` at the `sclk` rising edges. A swapped bit order or a lost bit therefore shows up both in the rebuilt byte and in the receive buffer as soon as that byte finishes.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_BAUD = 3'd1,
    RA_TXB  = 3'd2,
    RA_RXB  = 3'd3,
    RA_IE   = 3'd4,
    RA_IFG  = 3'd5,
    RA_VEC  = 3'd6
  } reg_addr_e;

  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] VEC_NONE = 4'd0;
  localparam logic [VEC_W-1:0] VEC_RX   = 4'd2;
  localparam logic [VEC_W-1:0] VEC_TX   = 4'd4;

  // interrupt enable / flag bit positions
  localparam int IRQ_RX  = 0;
  localparam int IRQ_TX  = 1;
  localparam int IRQ_OVR = 2;

endpackage

// File: rtl/spim_rstsync.sv
module spim_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bit_end,
  output logic             sclk_hi
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign div_eff = (div < DIV_MIN) ? DIV_MIN : div;
  assign half    = div_eff >> 1;
  assign bit_end = run && (cnt_q == div_eff - 1'b1);
  assign sclk_hi = run && (cnt_q >= half);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || bit_end) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: counter never passes the end of a bit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_eff));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               swrst,
  input  logic               wr_tx,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               bit_end,
  input  logic               miso,
  output logic               busy,
  output logic               mosi,
  output logic               load,
  output logic               rx_done,
  output logic [FRAME_W-1:0] rx_data
);
  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] hold_q, hold_d;
  logic               hold_full_q, hold_full_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   bitcnt_q, bitcnt_d;
  logic               busy_q, busy_d;
  logic               last_bit;

  assign last_bit = (bitcnt_q == LAST);
  assign load     = !swrst && hold_full_q && (!busy_q || (bit_end && last_bit));
  assign rx_done  = busy_q && bit_end && last_bit;
  assign rx_data  = {shreg_q[FRAME_W-2:0], miso};
  assign busy     = busy_q;
  assign mosi     = busy_q && shreg_q[FRAME_W-1];

  always_comb begin
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    shreg_d     = shreg_q;
    bitcnt_d    = bitcnt_q;
    busy_d      = busy_q;
    if (swrst) begin
      hold_full_d = 1'b0;
      busy_d      = 1'b0;
      bitcnt_d    = '0;
    end else begin
      if (load) begin
        shreg_d     = hold_q;
        bitcnt_d    = '0;
        busy_d      = 1'b1;
        hold_full_d = 1'b0;
      end else if (busy_q && bit_end) begin
        shreg_d  = {shreg_q[FRAME_W-2:0], miso};
        bitcnt_d = bitcnt_q + 1'b1;
        if (last_bit) busy_d = 1'b0;
      end
      if (wr_tx) begin
        hold_d      = wr_data;
        hold_full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shreg_q     <= '0;
      bitcnt_q    <= '0;
      busy_q      <= 1'b0;
    end else begin
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      shreg_q     <= shreg_d;
      bitcnt_q    <= bitcnt_d;
      busy_q      <= busy_d;
    end
  end

  // R2: soft reset idles the shifter
  a_r2_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> !busy_q);
  // R6: a pending byte follows the last bit with no idle gap
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && hold_full_q && !swrst) |=> (busy_q && bitcnt_q == '0));
endmodule

// File: rtl/spim_irq.sv
module spim_irq
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swrst,
  input  logic             swrst_clr,
  input  logic             wr_tx,
  input  logic             load,
  input  logic             rx_done,
  input  logic             rd_rxbuf,
  input  logic             rd_vec,
  input  logic [1:0]       ie,
  output logic             rxifg,
  output logic             txifg,
  output logic             ovr,
  output logic [VEC_W-1:0] vec
);
  logic rxifg_q, rxifg_d, txifg_q, txifg_d, ovr_q, ovr_d;
  logic clr_rx, clr_tx;

  always_comb begin
    if (rxifg_q && ie[IRQ_RX])      vec = VEC_RX;
    else if (txifg_q && ie[IRQ_TX]) vec = VEC_TX;
    else                            vec = VEC_NONE;
  end

  assign clr_rx = rd_rxbuf || (rd_vec && vec == VEC_RX);
  assign clr_tx = rd_vec && (vec == VEC_TX);

  always_comb begin
    txifg_d = txifg_q;
    rxifg_d = rxifg_q;
    ovr_d   = ovr_q;
    if (swrst) begin
      txifg_d = swrst_clr;
      rxifg_d = 1'b0;
      ovr_d   = 1'b0;
    end else begin
      if (wr_tx)       txifg_d = 1'b0;
      else if (load)   txifg_d = 1'b1;
      else if (clr_tx) txifg_d = 1'b0;

      if (rx_done) begin
        rxifg_d = 1'b1;
        if (rxifg_q && !clr_rx) ovr_d = 1'b1;
      end else if (clr_rx) begin
        rxifg_d = 1'b0;
      end
      if (rd_rxbuf && !rx_done) ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txifg_q <= 1'b0;
      rxifg_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      txifg_q <= txifg_d;
      rxifg_q <= rxifg_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rxifg = rxifg_q;
  assign txifg = txifg_q;
  assign ovr   = ovr_q;

  // R5: moving the holding byte into the shifter raises transmit-ready
  a_r5_ready_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_tx) |=> txifg_q);
  // R7: a finished byte always leaves receive-complete set
  a_r7_rx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !swrst) |=> rxifg_q);
  // R8: overrun only rises while a byte was already waiting
  a_r8_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rxifg_q));
  // R10: a vector read of the transmit code drops transmit-ready
  a_r10_vec_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && !wr_tx && !load && !swrst) |=> !txifg_q);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 16,
  parameter int BUS_W   = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sclk,
  input  logic              miso,
  output logic              mosi
);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(2);

  logic rst_i_n;
  logic wr_en, rd_en;
  logic wr_ctrl, wr_baud, wr_tx, wr_ie, rd_rxbuf, rd_vec;
  logic swrst_q, swrst_d, swrst_clr;
  logic [DIV_W-1:0] baud_q, baud_d;
  logic [1:0] ie_q, ie_d;
  logic [FRAME_W-1:0] rxbuf_q, rxbuf_d;
  logic busy, load, rx_done, bit_end, sclk_hi;
  logic [FRAME_W-1:0] rx_data;
  logic rxifg, txifg, ovr;
  logic [VEC_W-1:0] vec;
  logic unused_wdata;

  spim_rstsync #(.STAGES(2)) i_rstsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign wr_en     = bus_sel && bus_wr;
  assign rd_en     = bus_sel && !bus_wr;
  assign wr_ctrl   = wr_en && bus_addr == RA_CTRL;
  assign wr_baud   = wr_en && bus_addr == RA_BAUD;
  assign wr_tx     = wr_en && bus_addr == RA_TXB && !swrst_q;
  assign wr_ie     = wr_en && bus_addr == RA_IE;
  assign rd_rxbuf  = rd_en && bus_addr == RA_RXB;
  assign rd_vec    = rd_en && bus_addr == RA_VEC;
  assign swrst_clr = wr_ctrl && swrst_q && !bus_wdata[0];
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    swrst_d = wr_ctrl ? bus_wdata[0] : swrst_q;
    baud_d  = wr_baud ? bus_wdata[DIV_W-1:0] : baud_q;
    ie_d    = wr_ie   ? bus_wdata[1:0] : ie_q;
    rxbuf_d = rx_done ? rx_data : rxbuf_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      swrst_q <= 1'b1;
      baud_q  <= DIV_RESET;
      ie_q    <= '0;
      rxbuf_q <= '0;
    end else begin
      swrst_q <= swrst_d;
      baud_q  <= baud_d;
      ie_q    <= ie_d;
      rxbuf_q <= rxbuf_d;
    end
  end

  spim_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_i_n), .run(busy), .div(baud_q),
    .bit_end(bit_end), .sclk_hi(sclk_hi)
  );

  spim_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_i_n), .swrst(swrst_q), .wr_tx(wr_tx),
    .wr_data(bus_wdata[FRAME_W-1:0]), .bit_end(bit_end), .miso(miso),
    .busy(busy), .mosi(mosi), .load(load), .rx_done(rx_done),
    .rx_data(rx_data)
  );

  spim_irq i_irq (
    .clk(clk), .rst_n(rst_i_n), .swrst(swrst_q), .swrst_clr(swrst_clr),
    .wr_tx(wr_tx), .load(load), .rx_done(rx_done), .rd_rxbuf(rd_rxbuf),
    .rd_vec(rd_vec), .ie(ie_q), .rxifg(rxifg), .txifg(txifg), .ovr(ovr),
    .vec(vec)
  );

  assign sclk = sclk_hi;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        RA_CTRL: bus_rdata = BUS_W'(swrst_q);
        RA_BAUD: bus_rdata = BUS_W'(baud_q);
        RA_RXB:  bus_rdata = BUS_W'(rxbuf_q);
        RA_IE:   bus_rdata = BUS_W'(ie_q);
        RA_IFG:  bus_rdata = BUS_W'({ovr, txifg, rxifg});
        RA_VEC:  bus_rdata = BUS_W'(vec);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: no bit clock while soft reset is held
  a_r2_no_sclk_in_reset: assert property (@(posedge clk) disable iff (!rst_i_n)
    swrst_q |=> !sclk);
  // R3: clearing soft reset leaves transmit-ready set
  a_r3_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_i_n)
    swrst_clr |=> txifg);
  // R7: the receive buffer only changes on a completed byte
  a_r7_rxbuf_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rx_done |=> $stable(rxbuf_q));
endmodule

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        sclk, mosi, miso;

  int total, bad;
  logic done;

  // monitor state
  logic        mon_clr;
  logic        sclk_prev;
  int          cyc, rises, last_rise, gmin, gmax;
  logic [7:0]  cap;

  // table: [23:8] divisor written, [7:0] byte
  localparam int NTAB = 5;
  localparam logic [NTAB-1:0][23:0] TAB = '{
    {16'd2, 8'h01}, {16'd5, 8'h7E}, {16'd0, 8'h81},
    {16'd3, 8'h3C}, {16'd2, 8'hA5}
  };

  assign miso = mosi;  // loopback

  spim_top i_spim_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .miso(miso), .mosi(mosi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      rises = 0; gmin = 1 << 20; gmax = 0; cap = '0;
    end else if (sclk && !sclk_prev) begin
      if (rises != 0) begin
        if (cyc - last_rise < gmin) gmin = cyc - last_rise;
        if (cyc - last_rise > gmax) gmax = cyc - last_rise;
      end
      last_rise = cyc;
      rises = rises + 1;
      cap = {cap[6:0], mosi};
    end
    sclk_prev = sclk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic clr_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    total = 0; bad = 0;
    cyc = 0; rises = 0; last_rise = 0; gmin = 0; gmax = 0; cap = '0;
    sclk_prev = 1'b0; mon_clr = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 16'h1);
    rd(3'd1, d); check("R1 divisor", d, 16'h2);
    rd(3'd5, d); check("R1 flags", d, 16'h0);
    rd(3'd6, d); check("R1 vector", d, 16'h0);
    check("R1 sclk", sclk, 1'b0);
    check("R1 mosi", mosi, 1'b0);

    // R2 write while soft reset is held is discarded
    clr_mon();
    wr(3'd2, 16'h00F7);
    idle(40);
    check("R2 no sclk in reset", rises, 0);

    // R3 clearing soft reset raises transmit-ready
    wr(3'd0, 16'h0000);
    rd(3'd5, d); check("R3 ready after reset", d, 16'h2);
    idle(40);
    check("R2 discarded byte not sent", rises, 0);

    // table: R4 R7 R11
    for (int i = 0; i < NTAB; i++) begin
      int eff;
      eff = (TAB[i][23:8] < 2) ? 2 : int'(TAB[i][23:8]);
      wr(3'd1, TAB[i][23:8]);
      clr_mon();
      wr(3'd2, {8'h00, TAB[i][7:0]});
      idle(8 * eff + 12);
      check("R4 edge count", rises, 8);
      check("R4 R11 bit period max", gmax, eff);
      check("R4 R11 bit period min", gmin, eff);
      check("R4 msb first on mosi", cap, TAB[i][7:0]);
      rd(3'd3, d); check("R7 rx byte", d, {8'h00, TAB[i][7:0]});
      rd(3'd5, d); check("R7 rx flag cleared", d[0], 1'b0);
    end

    // R5 R6 R8: streaming two bytes, divisor 4
    wr(3'd1, 16'd4);
    clr_mon();
    wr(3'd2, 16'h00C3);
    rd(3'd5, d); check("R5 ready set at byte start", d[1], 1'b1);
    wr(3'd2, 16'h005A);
    rd(3'd5, d); check("R5 ready cleared by write", d[1], 1'b0);
    idle(80);
    check("R6 edge count", rises, 16);
    check("R6 no gap max", gmax, 4);
    check("R6 no gap min", gmin, 4);
    rd(3'd5, d); check("R8 overrun set", d, 16'h7);
    rd(3'd3, d); check("R7 R8 last byte kept", d, 16'h005A);
    rd(3'd5, d); check("R8 overrun cleared", d, 16'h2);

    // R9 R10 vector
    wr(3'd4, 16'h3);
    rd(3'd6, d); check("R9 tx code", d, 16'h4);
    rd(3'd6, d); check("R10 tx cleared by vector", d, 16'h0);
    wr(3'd2, 16'h0099);
    idle(50);
    wr(3'd4, 16'h2);
    rd(3'd6, d); check("R9 rx disabled not reported", d, 16'h4);
    wr(3'd4, 16'h3);
    rd(3'd6, d); check("R9 rx has priority", d, 16'h2);
    rd(3'd5, d); check("R10 only rx cleared", d, 16'h0);
    rd(3'd6, d); check("R10 vector empty", d, 16'h0);
    rd(3'd3, d); check("R7 rx byte after vector", d, 16'h0099);
    check("R6 idle sclk low", sclk, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule